// File: doc/BRIEF.md
# Move-to-Front Translation Buffer

This block is a small fully associative address translation buffer. Its entries are held in strict recency order: slot 0 is the most recently used entry and the highest slot is the least recently used one. A lookup takes a virtual address and a context tag. It returns, in the same cycle, a hit flag, the translated physical address and the entry's attribute bits. An ordinary hit physically moves the matching entry to slot 0. A probe lookup reports the same result but leaves the order untouched. Refills come from an external page walker through an insert port. An insert pushes every entry one slot toward the tail and drops the entry in the last slot.

Each entry holds a page shift N. The page base is `vpn << N` and the page spans `1 << N` bytes. The physical address is `(pfn << N)` with the low N bits of the virtual address placed under it. Entries flagged global match any context. Four maintenance operations remove entries: wipe everything, remove by context, remove by address range, and remove by address plus context. A small controller runs them one scan pass per cycle and raises `busy` while it works. Lookups made while busy are stalled. Four hit and miss counters, split by read and write, record ordinary lookups, and the block also outputs their sums.

The controller has three states. IDLE accepts a command. SWEEP is a single pass for the wipe, context and range operations, and returns to IDLE. HUNT removes the first entry that matches the address and context on each cycle. HUNT stays in place while a match exists and returns to IDLE on the first cycle it finds none.

Top module: `tlb_mtf`

## Requirements
- R1: After reset every entry is invalid, `busy` is 0, every counter is 0, and any lookup misses.
- R2: A hit returns `lk_pa = (pfn << N) | (lk_va & ((1<<N)-1))` and that entry's attribute bits, for N = 12 and N = 16 alike.
- R3: An entry matches when it is valid, `lk_va >> N == vpn`, and either its context equals `lk_ctx` or it is global. A non-global entry never matches another context.
- R4: When several entries match, the one in the lowest slot (the most recent) supplies the result.
- R5: An ordinary hit (`lk_probe`=0) at slot x moves that entry to slot 0 and shifts slots 0..x-1 down by one. Slots above x are unchanged.
- R6: A probe hit (`lk_probe`=1) returns the same result as an ordinary hit and leaves the order and contents unchanged.
- R7: An insert places the new entry at slot 0, shifts all others down by one, and discards the entry in the last slot. An insert in the same cycle as a lookup wins, and the lookup does not reorder.
- R8: Command `mt_op`=0 (wipe all) clears every entry in one pass.
- R9: Command `mt_op`=2 clears, in one pass, every valid entry whose context equals `mt_ctx`, including global entries with that context. Other entries survive.
- R10: Command `mt_op`=3 clears, in one pass, every entry whose page contains `mt_va`, whatever its context.
- R11: Command `mt_op`=1 clears the first entry matching `mt_va`/`mt_ctx` (global included) on each cycle. It repeats until none is left, so with k copies `busy` stays high for k+1 cycles.
- R12: A command is accepted only while IDLE, and `busy` rises in the next cycle. While busy, a lookup reports a miss and is not counted, and inserts and new commands are ignored.
- R13: Each ordinary lookup while not busy increments exactly one of `rd_hits`, `rd_misses`, `wr_hits`, `wr_misses`, chosen by `lk_write` and the outcome. Probes are not counted. `hits`, `misses` and `accesses` are the read+write sums.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_probe | input | 1 | Lookup does not reorder and is not counted |
| lk_write | input | 1 | Lookup is for a write (counter selection) |
| lk_va | input | 32 | Lookup virtual address |
| lk_ctx | input | 8 | Lookup context tag |
| lk_hit | output | 1 | Lookup hit |
| lk_pa | output | 32 | Translated physical address (0 on miss) |
| lk_attr | output | 4 | Attribute bits of the hit entry |
| ins_valid | input | 1 | Insert request |
| ins_glob | input | 1 | New entry is global |
| ins_asid | input | 8 | New entry context tag |
| ins_shift | input | 5 | New entry page shift N |
| ins_vpn | input | 32 | New entry virtual page number |
| ins_pfn | input | 32 | New entry physical frame number |
| ins_attr | input | 4 | New entry attribute bits |
| mt_valid | input | 1 | Maintenance command request |
| mt_op | input | 2 | 0 wipe all, 1 address+context, 2 context, 3 address range |
| mt_va | input | 32 | Command address |
| mt_ctx | input | 8 | Command context tag |
| busy | output | 1 | Maintenance in progress |
| rd_hits | output | 16 | Read hit count |
| rd_misses | output | 16 | Read miss count |
| wr_hits | output | 16 | Write hit count |
| wr_misses | output | 16 | Write miss count |
| hits | output | 17 | Read plus write hits |
| misses | output | 17 | Read plus write misses |
| accesses | output | 17 | All counted lookups |

## Verification
Recency order is never visible at the ports, so the bench reveals it through eviction. It fills the buffer, touches one entry with a lookup or a probe, inserts one more, and then checks which entry is gone. The repeated address-plus-context pass is the hardest case to reach: it needs duplicate entries, which the stimulus creates by inserting the same translation twice. The bench then counts the busy cycles and issues a stalled lookup during the first of them.

// File: rtl/tlb_mtf_pkg.sv
package tlb_mtf_pkg;
    parameter int VA_W    = 32;
    parameter int ASID_W  = 8;
    parameter int SHIFT_W = 5;
    parameter int ATTR_W  = 4;

    typedef struct packed {
        logic               valid;
        logic               glob;
        logic [ASID_W-1:0]  asid;
        logic [SHIFT_W-1:0] shift;
        logic [VA_W-1:0]    vpn;
        logic [VA_W-1:0]    pfn;
        logic [ATTR_W-1:0]  attr;
    } tlb_entry_t;

    typedef enum logic [1:0] {
        OP_ALL    = 2'd0,
        OP_VA_CTX = 2'd1,
        OP_CTX    = 2'd2,
        OP_RANGE  = 2'd3
    } maint_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SWEEP = 2'd1,
        ST_HUNT  = 2'd2
    } maint_state_e;
endpackage

// File: rtl/tlb_slot_cmp.sv
module tlb_slot_cmp
    import tlb_mtf_pkg::*;
(
    input  tlb_entry_t        ent,
    input  logic [VA_W-1:0]   va,
    input  logic [ASID_W-1:0] ctx,
    output logic              page_hit,
    output logic              ctx_eq
);
    always_comb begin
        page_hit = ent.valid && ((va >> ent.shift) == ent.vpn);
        ctx_eq   = ent.valid && (ent.asid == ctx);
    end
endmodule

// File: rtl/tlb_maint_ctl.sv
module tlb_maint_ctl
    import tlb_mtf_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmd_valid,
    input  maint_op_e    cmd_op,
    input  logic         hunt_hit,
    output maint_state_e state,
    output maint_op_e    op_q,
    output logic         busy,
    output logic         accept
);
    maint_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            op_q  <= OP_ALL;
        end else begin
            state <= nxt;
            if (accept) op_q <= cmd_op;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (cmd_valid) nxt = (cmd_op == OP_VA_CTX) ? ST_HUNT : ST_SWEEP;
            ST_SWEEP: nxt = ST_IDLE;
            ST_HUNT:  nxt = hunt_hit ? ST_HUNT : ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        busy   = (state != ST_IDLE);
        accept = (state == ST_IDLE) && cmd_valid;
    end

    AST_SWEEP_SINGLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SWEEP) |=> (state == ST_IDLE)); // R8
    AST_ACCEPT_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid) |=> busy); // R12
endmodule

// File: rtl/tlb_hit_counters.sv
module tlb_hit_counters #(
    parameter int CNT_W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           count_en,
    input  logic           is_write,
    input  logic           hit,
    output logic [CNT_W-1:0] rd_hits,
    output logic [CNT_W-1:0] rd_misses,
    output logic [CNT_W-1:0] wr_hits,
    output logic [CNT_W-1:0] wr_misses,
    output logic [CNT_W:0]   hits,
    output logic [CNT_W:0]   misses,
    output logic [CNT_W:0]   accesses
);
    localparam int NCNT = 4;
    logic [CNT_W-1:0] cnt [NCNT];
    logic [1:0]       sel;

    assign sel = {is_write, ~hit};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NCNT; i++) cnt[i] <= '0;
        end else if (count_en) begin
            for (int i = 0; i < NCNT; i++)
                if (sel == 2'(i)) cnt[i] <= cnt[i] + 1'b1;
        end
    end

    always_comb begin
        rd_hits   = cnt[0];
        rd_misses = cnt[1];
        wr_hits   = cnt[2];
        wr_misses = cnt[3];
        hits      = {1'b0, cnt[0]} + {1'b0, cnt[2]};
        misses    = {1'b0, cnt[1]} + {1'b0, cnt[3]};
        accesses  = hits + misses;
    end

    AST_READ_HIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en && !is_write && hit) |=> (rd_hits == $past(rd_hits) + 1'b1)); // R13
    AST_WRITE_MISS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en && is_write && !hit) |=> (wr_misses == $past(wr_misses) + 1'b1)); // R13
endmodule

// File: rtl/tlb_mtf.sv
module tlb_mtf
    import tlb_mtf_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lk_valid,
    input  logic               lk_probe,
    input  logic               lk_write,
    input  logic [VA_W-1:0]    lk_va,
    input  logic [ASID_W-1:0]  lk_ctx,
    output logic               lk_hit,
    output logic [VA_W-1:0]    lk_pa,
    output logic [ATTR_W-1:0]  lk_attr,
    input  logic               ins_valid,
    input  logic               ins_glob,
    input  logic [ASID_W-1:0]  ins_asid,
    input  logic [SHIFT_W-1:0] ins_shift,
    input  logic [VA_W-1:0]    ins_vpn,
    input  logic [VA_W-1:0]    ins_pfn,
    input  logic [ATTR_W-1:0]  ins_attr,
    input  logic               mt_valid,
    input  logic [1:0]         mt_op,
    input  logic [VA_W-1:0]    mt_va,
    input  logic [ASID_W-1:0]  mt_ctx,
    output logic               busy,
    output logic [CNT_W-1:0]   rd_hits,
    output logic [CNT_W-1:0]   rd_misses,
    output logic [CNT_W-1:0]   wr_hits,
    output logic [CNT_W-1:0]   wr_misses,
    output logic [CNT_W:0]     hits,
    output logic [CNT_W:0]     misses,
    output logic [CNT_W:0]     accesses
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    tlb_entry_t [DEPTH-1:0] tab, tab_nxt;
    tlb_entry_t             ins_ent, hit_ent;
    logic [DEPTH-1:0] lk_page, lk_ctxeq, lk_match;
    logic [DEPTH-1:0] mt_page, mt_ctxeq, mt_full, valid_vec;
    logic [VA_W-1:0]   mt_va_q;
    logic [ASID_W-1:0] mt_ctx_q;
    logic [IDX_W-1:0]  lk_idx, mt_idx;
    logic              lk_found, mt_found, accept, count_en;
    maint_state_e      state;
    maint_op_e         op_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        tlb_slot_cmp u_lk_cmp (.ent(tab[g]), .va(lk_va), .ctx(lk_ctx),
                               .page_hit(lk_page[g]), .ctx_eq(lk_ctxeq[g]));
        tlb_slot_cmp u_mt_cmp (.ent(tab[g]), .va(mt_va_q), .ctx(mt_ctx_q),
                               .page_hit(mt_page[g]), .ctx_eq(mt_ctxeq[g]));
        assign lk_match[g]  = lk_page[g] && (lk_ctxeq[g] || tab[g].glob);
        assign mt_full[g]   = mt_page[g] && (mt_ctxeq[g] || tab[g].glob);
        assign valid_vec[g] = tab[g].valid;
    end

    tlb_maint_ctl u_ctl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(mt_valid), .cmd_op(maint_op_e'(mt_op)),
        .hunt_hit(mt_found), .state(state), .op_q(op_q), .busy(busy), .accept(accept)
    );

    // lowest slot wins: scan downward so the last assignment is the lowest index
    always_comb begin
        lk_found = 1'b0; lk_idx = '0;
        mt_found = 1'b0; mt_idx = '0;
        for (int i = DEPTH-1; i >= 0; i--) begin
            if (lk_match[i]) begin lk_found = 1'b1; lk_idx = IDX_W'(i); end
            if (mt_full[i])  begin mt_found = 1'b1; mt_idx = IDX_W'(i); end
        end
    end

    always_comb begin
        hit_ent  = tab[lk_idx];
        lk_hit   = lk_valid && !busy && lk_found;
        lk_pa    = '0;
        lk_attr  = '0;
        if (lk_hit) begin
            lk_pa   = (hit_ent.pfn << hit_ent.shift)
                    | (lk_va & ((VA_W'(1) << hit_ent.shift) - VA_W'(1)));
            lk_attr = hit_ent.attr;
        end
        count_en = lk_valid && !lk_probe && !busy;
    end

    always_comb begin
        ins_ent       = '0;
        ins_ent.valid = 1'b1;
        ins_ent.glob  = ins_glob;
        ins_ent.asid  = ins_asid;
        ins_ent.shift = ins_shift;
        ins_ent.vpn   = ins_vpn;
        ins_ent.pfn   = ins_pfn;
        ins_ent.attr  = ins_attr;
    end

    always_comb begin
        tab_nxt = tab;
        unique case (state)
            ST_SWEEP: begin
                for (int i = 0; i < DEPTH; i++)
                    if (op_q == OP_ALL || (op_q == OP_CTX && mt_ctxeq[i]) ||
                        (op_q == OP_RANGE && mt_page[i]))
                        tab_nxt[i] = '0;
            end
            ST_HUNT: begin
                if (mt_found) tab_nxt[mt_idx] = '0;
            end
            ST_IDLE: begin
                if (ins_valid) begin
                    tab_nxt[0] = ins_ent;
                    for (int i = 1; i < DEPTH; i++) tab_nxt[i] = tab[i-1];
                end else if (lk_valid && !lk_probe && lk_found) begin
                    tab_nxt[0] = hit_ent;
                    for (int i = 1; i < DEPTH; i++)
                        if (i <= int'(lk_idx)) tab_nxt[i] = tab[i-1];
                end
            end
            default: tab_nxt = tab;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tab      <= '0;
            mt_va_q  <= '0;
            mt_ctx_q <= '0;
        end else begin
            tab <= tab_nxt;
            if (accept) begin
                mt_va_q  <= mt_va;
                mt_ctx_q <= mt_ctx;
            end
        end
    end

    tlb_hit_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .count_en(count_en), .is_write(lk_write), .hit(lk_found),
        .rd_hits(rd_hits), .rd_misses(rd_misses), .wr_hits(wr_hits), .wr_misses(wr_misses),
        .hits(hits), .misses(misses), .accesses(accesses)
    );

    AST_HIT_TO_FRONT: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_probe && !busy && lk_found && !ins_valid) |=> (tab[0] == $past(hit_ent))); // R5
    AST_PROBE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !ins_valid && (!lk_valid || lk_probe)) |=> $stable(tab)); // R6
    AST_INSERT_AT_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && ins_valid) |=> (tab[0] == $past(ins_ent))); // R7
    AST_WIPE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SWEEP && op_q == OP_ALL) |=> (valid_vec == '0)); // R8
    AST_HUNT_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HUNT && mt_found) |=> ($countones(mt_full) < $countones($past(mt_full)))); // R11
    AST_STALL_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(accesses)); // R12
endmodule

// File: tb/tlb_mtf_test.sv
`timescale 1ns/1ps
module tlb_mtf_test;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        lk_valid = 0, lk_probe = 0, lk_write = 0;
    logic [31:0] lk_va = '0;
    logic [7:0]  lk_ctx = '0;
    logic        lk_hit;
    logic [31:0] lk_pa;
    logic [3:0]  lk_attr;
    logic        ins_valid = 0, ins_glob = 0;
    logic [7:0]  ins_asid = '0;
    logic [4:0]  ins_shift = '0;
    logic [31:0] ins_vpn = '0, ins_pfn = '0;
    logic [3:0]  ins_attr = '0;
    logic        mt_valid = 0;
    logic [1:0]  mt_op = '0;
    logic [31:0] mt_va = '0;
    logic [7:0]  mt_ctx = '0;
    logic        busy;
    logic [15:0] rd_hits, rd_misses, wr_hits, wr_misses;
    logic [16:0] hits, misses, accesses;

    int total = 0, bad = 0;
    int e_rh = 0, e_rm = 0, e_wh = 0, e_wm = 0;
    bit done = 0;

    typedef struct {
        int          rq;
        logic        hit;
        logic [31:0] pa;
        logic [3:0]  attr;
    } exp_t;
    exp_t sbq[$];

    always #4 clk = ~clk;

    tlb_mtf uut (.*);

    task automatic report();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic chk(input int rq, input logic [63:0] act, input logic [63:0] exp_v);
        total++;
        if (act !== exp_v) begin
            bad++;
            $display("FAIL R%0d act=%h exp=%h", rq, act, exp_v);
        end
    endtask

    // monitor: pops one expectation per lookup cycle, compares mid-cycle
    initial forever begin
        @(negedge clk);
        #3;
        if (sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            total++;
            if (lk_hit !== e.hit || (e.hit && (lk_pa !== e.pa || lk_attr !== e.attr))) begin
                bad++;
                $display("FAIL R%0d lookup act hit=%b pa=%h attr=%h exp hit=%b pa=%h attr=%h",
                         e.rq, lk_hit, lk_pa, lk_attr, e.hit, e.pa, e.attr);
            end
        end
    end

    task automatic look(input int rq, input logic [31:0] va, input logic [7:0] ctx,
                        input logic wr, input logic prb, input logic eh,
                        input logic [31:0] epa, input logic [3:0] eat, input logic stalled);
        @(negedge clk);
        lk_valid = 1; lk_va = va; lk_ctx = ctx; lk_write = wr; lk_probe = prb;
        sbq.push_back('{rq, eh, epa, eat});
        if (!prb && !stalled) begin
            if (wr) begin if (eh) e_wh++; else e_wm++; end
            else    begin if (eh) e_rh++; else e_rm++; end
        end
        @(posedge clk); #1;
        lk_valid = 0; lk_probe = 0; lk_write = 0;
    endtask

    task automatic ins(input logic gl, input logic [7:0] asid, input logic [4:0] sh,
                       input logic [31:0] vpn, input logic [31:0] pfn, input logic [3:0] at);
        @(negedge clk);
        ins_valid = 1; ins_glob = gl; ins_asid = asid; ins_shift = sh;
        ins_vpn = vpn; ins_pfn = pfn; ins_attr = at;
        @(posedge clk); #1;
        ins_valid = 0;
    endtask

    task automatic cmd(input logic [1:0] op, input logic [31:0] va, input logic [7:0] ctx);
        @(negedge clk);
        mt_valid = 1; mt_op = op; mt_va = va; mt_ctx = ctx;
        @(posedge clk); #1;
        mt_valid = 0;
    endtask

    task automatic wait_idle();
        do begin @(negedge clk); #3; end while (busy);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        int nb;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk); #3;
        chk(1, busy, 0);                                 // R1
        chk(1, accesses, 0);                             // R1
        look(1, 32'h0001_0123, 8'd5, 0, 0, 0, 0, 0, 0);  // R1 empty -> miss

        ins(0, 8'd5, 5'd12, 32'h10, 32'hABC, 4'h3);      // E1
        look(2, 32'h0001_0123, 8'd5, 0, 0, 1, 32'h00AB_C123, 4'h3, 0); // R2 N=12
        look(3, 32'h0001_0123, 8'd6, 1, 0, 0, 0, 0, 0);  // R3 other context misses
        ins(1, 8'd1, 5'd16, 32'h2, 32'h77, 4'h9);        // E2 global, N=16
        look(2, 32'h0002_BEEF, 8'd9, 1, 0, 1, 32'h0077_BEEF, 4'h9, 0); // R2 R3 global
        ins(0, 8'd5, 5'd12, 32'h30, 32'h300, 4'h1);      // E3
        ins(0, 8'd5, 5'd12, 32'h40, 32'h400, 4'h2);      // E4 -> [E4,E3,E2,E1]
        look(5, 32'h0001_0000, 8'd5, 0, 0, 1, 32'h00AB_C000, 4'h3, 0); // R5 E1 to front
        ins(0, 8'd5, 5'd12, 32'h50, 32'h500, 4'h4);      // E5 evicts E2 (R7)
        look(7, 32'h0002_0000, 8'd9, 0, 0, 0, 0, 0, 0);  // R7 E2 gone
        look(5, 32'h0001_0004, 8'd5, 1, 0, 1, 32'h00AB_C004, 4'h3, 0); // R5 E1 survived
        look(6, 32'h0003_0010, 8'd5, 0, 1, 1, 32'h0030_0010, 4'h1, 0); // R6 probe E3 (last)
        ins(0, 8'd5, 5'd12, 32'h60, 32'h600, 4'h5);      // E6 evicts E3 since probe kept order
        look(6, 32'h0003_0010, 8'd5, 0, 0, 0, 0, 0, 0);  // R6 E3 evicted
        ins(1, 8'd0, 5'd12, 32'h60, 32'h777, 4'h6);      // E7 global, same page as E6
        look(4, 32'h0006_0004, 8'd5, 0, 0, 1, 32'h0077_7004, 4'h6, 0); // R4 lowest slot wins

        cmd(2'd2, 32'h0, 8'd5);                          // R9 remove context 5
        wait_idle();
        look(9, 32'h0001_0000, 8'd5, 0, 0, 0, 0, 0, 0);  // R9 E1 gone
        look(9, 32'h0006_0004, 8'd5, 0, 0, 1, 32'h0077_7004, 4'h6, 0); // R9 global ctx0 stays

        ins(0, 8'd3, 5'd16, 32'h9, 32'h88, 4'h7);        // E8
        cmd(2'd3, 32'h0009_FFFF, 8'd0);                  // R10 range, any context
        wait_idle();
        look(10, 32'h0009_0000, 8'd3, 0, 0, 0, 0, 0, 0); // R10 E8 gone
        look(10, 32'h0006_0000, 8'd1, 0, 0, 1, 32'h0077_7000, 4'h6, 0); // R10 E7 kept

        ins(0, 8'd2, 5'd12, 32'h90, 32'h900, 4'h8);      // E9 copy 1
        ins(0, 8'd2, 5'd12, 32'h90, 32'h900, 4'h8);      // E9 copy 2
        cmd(2'd1, 32'h0009_0000, 8'd2);                  // R11 hunt
        look(12, 32'h0006_0000, 8'd1, 0, 0, 0, 0, 0, 1); // R12 stalled lookup misses
        nb = 1;
        forever begin
            @(negedge clk); #3;
            if (!busy) break;
            nb++;
        end
        chk(11, nb, 3);                                  // R11 two copies -> 3 busy cycles
        look(11, 32'h0009_0000, 8'd2, 0, 0, 0, 0, 0, 0); // R11 no copy left
        look(11, 32'h0006_0000, 8'd1, 1, 0, 1, 32'h0077_7000, 4'h6, 0); // R11 E7 kept

        cmd(2'd0, 32'h0, 8'd0);                          // R8 wipe all
        ins(0, 8'd4, 5'd12, 32'hA0, 32'hA00, 4'hA);      // R12 insert while busy ignored
        wait_idle();
        look(8, 32'h0006_0000, 8'd1, 0, 0, 0, 0, 0, 0);  // R8 E7 gone
        look(12, 32'h000A_0000, 8'd4, 1, 0, 0, 0, 0, 0); // R12 ignored insert absent

        @(negedge clk); #3;
        chk(13, rd_hits, e_rh);                          // R13
        chk(13, rd_misses, e_rm);                        // R13
        chk(13, wr_hits, e_wh);                          // R13
        chk(13, wr_misses, e_wm);                        // R13
        chk(13, hits, e_rh + e_wh);                      // R13
        chk(13, misses, e_rm + e_wm);                    // R13
        chk(13, accesses, e_rh + e_rm + e_wh + e_wm);    // R13
        done = 1;
        report();
    end
endmodule